// File: doc/BRIEF.md
# HDLC Burst Frame Builder

This block turns a payload held in a byte FIFO into a fully framed bit sequence and stores it, one bit per cycle, in an on-chip bit buffer. A frame is made of a 24-bit alternating training preamble, an opening flag, the payload with zero-bit insertion, a complemented 16-bit frame check sequence with zero-bit insertion, and a closing flag. The buffer is sized in slot units. The default is five slots of 256 bits, which is enough for a five-slot burst. A consumer reads the buffer through a combinational read port.

A build starts with a `start` pulse that carries the payload length in bytes. The block pulls bytes from the FIFO whenever it needs one, and it waits whenever the FIFO is empty. It counts every bit it writes. If a bit would land past the end of the buffer, the block stops and raises a sticky too-long error. A `query` pulse asks for the total frame length. The answer is held back until the build has ended, and it then arrives as a one-cycle `query_done` pulse with the count in `query_count`.

Top module: `hbb_frame_builder`

## Requirements
- R1: After reset, `done`, `too_long`, `query_done` and `fifo_pop` are 0 and `bit_count` is 0.
- R2: Buffer bit k holds the k-th emitted bit, in this order:
  - 24 preamble bits 0,1,0,1,… starting with 0.
  - The flag 0x7E, least significant bit first.
  - Each payload byte, least significant bit first.
  - The 16-bit check value, bit 0 first.
  - The flag 0x7E again.
- R3: In the payload and check-value fields, one 0 bit is inserted after every run of five consecutive 1 bits. The run continues across the boundary between payload and check value, and the run restarts after the inserted 0. Preamble and flags are never stuffed. A stuff bit that is due after the last check-value bit comes before the closing flag.
- R4: The check value is the complement of a 16-bit CRC with reflected polynomial 0x8408 and initial value 0xFFFF. The CRC is updated on every unstuffed payload bit in transmit order.
- R5: `bit_count` equals the number of bits written to the buffer, counting preamble, both flags, payload, check value and every inserted 0.
- R6: `done` rises after the last closing-flag bit is written. `done` and `too_long` are never both 1. While `done` is 1 and no new `start` arrives, `done` and `bit_count` hold.
- R7: A bit that would be written at index CAP (SLOT_BITS×SLOTS) is not written. Instead `too_long` goes to 1 and stays 1 until the next accepted `start`, `done` stays 0, and `bit_count` stays at CAP.
- R8: A `query` pulse is answered by exactly one `query_done` pulse, one cycle wide, carrying `query_count` = `bit_count`. The pulse comes only once the build has ended (`done` or `too_long`). The answer comes on the cycle after the end is first visible, or on the cycle after the query if the build had already ended, but not in a cycle where `start` is high.
- R9: A `start` pulse is ignored while a build is in progress, and the frame under construction is unchanged.
- R10: The block pops exactly `msg_len` bytes from the FIFO for a completed frame. When `fifo_valid` is low, the block waits without changing the resulting frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new build (accepted when no build is running) |
| msg_len | input | LEN_W | Payload length in bytes, sampled with an accepted start |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head byte this cycle |
| rd_addr | input | IW | Buffer read address |
| rd_bit | output | 1 | Buffer bit at rd_addr |
| query | input | 1 | Request the frame length |
| query_done | output | 1 | One-cycle answer pulse to a query |
| query_count | output | AW | Frame length returned with query_done |
| bit_count | output | AW | Bits written in the current build |
| done | output | 1 | Frame complete |
| too_long | output | 1 | Frame exceeded buffer capacity |

## Verification
The bench builds the block with SLOT_BITS=64, SLOTS=3 and LEN_W=5, which gives a 192-bit buffer. With that size, a sweep of payload lengths 0 to 20 bytes over zero, all-ones, mixed and flag-like byte patterns runs into both outcomes: frames that fit with room to spare or nearly fill the buffer, and frames that overflow it, with all-ones payloads hitting the stuffing limit and the capacity abort within a few hundred cycles. A small buffer also makes it cheap to read back every bit of every frame and compare it against an arithmetic model of the preamble, flags, stuffing and check value. The same sweep alternates FIFO stalls, checks a mid-build start, and checks queries issued both before and after completion.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_OPEN, ST_PAY, ST_FCS, ST_CLOSE, ST_DONE, ST_ERR
  } hbb_state_t;

  localparam logic [7:0] FLAG_PAT  = 8'h7E;
  localparam int         PRE_BITS  = 24;
  localparam int         RUN_LIMIT = 5;
endpackage

// File: rtl/hbb_crc16.sv
module hbb_crc16 #(
  parameter logic [15:0] POLY = 16'h8408,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic        din,
  output logic [15:0] crc
);
  logic [15:0] crc_d;

  always_comb begin
    crc_d = crc;
    if (init) begin
      crc_d = SEED;
    end else if (upd) begin
      crc_d = {1'b0, crc[15:1]} ^ ((crc[0] ^ din) ? POLY : 16'h0000);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= SEED;
    else        crc <= crc_d;
  end
endmodule

// File: rtl/hbb_bitmem.sv
module hbb_bitmem #(
  parameter int DEPTH = 1280,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic          wbit,
  input  logic [IW-1:0] raddr,
  output logic          rbit
);
  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
  end

  assign rbit = mem[raddr];
endmodule

// File: rtl/hbb_query.sv
module hbb_query #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          query,
  input  logic          start,
  input  logic          ended,
  input  logic [AW-1:0] count,
  output logic          query_done,
  output logic [AW-1:0] query_count
);
  logic pend_q, pend_d, fire;

  always_comb begin
    fire   = (pend_q || query) && ended && !start;
    pend_d = (pend_q || query) && !fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      query_done  <= 1'b0;
      query_count <= '0;
    end else begin
      pend_q     <= pend_d;
      query_done <= fire;
      if (fire) query_count <= count;
    end
  end

  // R8: an answer is only given once the build has ended
  assert_answer_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    query_done |-> $past(ended));
  // R8: the answer is a single-cycle pulse
  assert_answer_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    query_done |=> !query_done || $past(query) || $past(pend_q));
endmodule

// File: rtl/hbb_frame_builder.sv
module hbb_frame_builder
  import hbb_pkg::*;
#(
  parameter int SLOT_BITS = 256,
  parameter int SLOTS     = 5,
  parameter int LEN_W     = 8,
  localparam int CAP = SLOT_BITS * SLOTS,
  localparam int IW  = $clog2(CAP),
  localparam int AW  = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             fifo_valid,
  input  logic [7:0]       fifo_data,
  output logic             fifo_pop,
  input  logic [IW-1:0]    rd_addr,
  output logic             rd_bit,
  input  logic             query,
  output logic             query_done,
  output logic [AW-1:0]    query_count,
  output logic [AW-1:0]    bit_count,
  output logic             done,
  output logic             too_long
);
  hbb_state_t       state_q, state_d;
  logic [4:0]       idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d, nbytes_q, nbytes_d;
  logic [7:0]       byte_q;
  logic             have_q, have_d, stuff_q, stuff_d, load;
  logic [2:0]       ones_q, ones_d;
  logic [AW-1:0]    count_q, count_d;
  logic             emit, ebit, is_data, crc_init, full, we;
  logic [15:0]      crc;

  assign full = (count_q == AW'(CAP));
  assign we   = emit && !full;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    len_d    = len_q;
    nbytes_d = nbytes_q;
    have_d   = have_q;
    stuff_d  = stuff_q;
    ones_d   = ones_q;
    emit     = 1'b0;
    ebit     = 1'b0;
    is_data  = 1'b0;
    crc_init = 1'b0;
    load     = 1'b0;
    fifo_pop = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start) begin
          state_d  = ST_PRE;
          idx_d    = '0;
          len_d    = msg_len;
          nbytes_d = '0;
          have_d   = 1'b0;
          stuff_d  = 1'b0;
          ones_d   = '0;
          crc_init = 1'b1;
        end
      end
      ST_PRE: begin
        emit = 1'b1;
        ebit = idx_q[0];
        if (idx_q == 5'(PRE_BITS - 1)) begin
          idx_d   = '0;
          state_d = ST_OPEN;
        end else begin
          idx_d = idx_q + 5'd1;
        end
      end
      ST_OPEN: begin
        emit = 1'b1;
        ebit = FLAG_PAT[idx_q[2:0]];
        if (idx_q == 5'd7) begin
          idx_d   = '0;
          state_d = (len_q == '0) ? ST_FCS : ST_PAY;
        end else begin
          idx_d = idx_q + 5'd1;
        end
      end
      ST_PAY: begin
        if (stuff_q) begin
          emit    = 1'b1;
          stuff_d = 1'b0;
          ones_d  = '0;
        end else if (!have_q) begin
          fifo_pop = fifo_valid;
          load     = fifo_valid;
          have_d   = fifo_valid;
        end else begin
          emit    = 1'b1;
          is_data = 1'b1;
          ebit    = byte_q[idx_q[2:0]];
          if (idx_q == 5'd7) begin
            idx_d    = '0;
            have_d   = 1'b0;
            nbytes_d = nbytes_q + 1'b1;
            if (nbytes_d == len_q) state_d = ST_FCS;
          end else begin
            idx_d = idx_q + 5'd1;
          end
        end
      end
      ST_FCS: begin
        emit = 1'b1;
        if (stuff_q) begin
          stuff_d = 1'b0;
          ones_d  = '0;
        end else begin
          is_data = 1'b1;
          ebit    = ~crc[idx_q[3:0]];
          if (idx_q == 5'd15) begin
            idx_d   = '0;
            state_d = ST_CLOSE;
          end else begin
            idx_d = idx_q + 5'd1;
          end
        end
      end
      ST_CLOSE: begin
        emit = 1'b1;
        if (stuff_q) begin
          stuff_d = 1'b0;
          ones_d  = '0;
        end else begin
          ebit = FLAG_PAT[idx_q[2:0]];
          if (idx_q == 5'd7) state_d = ST_DONE;
          else               idx_d   = idx_q + 5'd1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (emit && is_data) begin
      ones_d = ebit ? ones_q + 3'd1 : 3'd0;
      if (ebit && ones_q == 3'(RUN_LIMIT - 1)) stuff_d = 1'b1;
    end
    if (emit && full) state_d = ST_ERR;
    count_d = crc_init ? '0 : (we ? count_q + 1'b1 : count_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      len_q    <= '0;
      nbytes_q <= '0;
      have_q   <= 1'b0;
      stuff_q  <= 1'b0;
      ones_q   <= '0;
      count_q  <= '0;
      byte_q   <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      len_q    <= len_d;
      nbytes_q <= nbytes_d;
      have_q   <= have_d;
      stuff_q  <= stuff_d;
      ones_q   <= ones_d;
      count_q  <= count_d;
      if (load) byte_q <= fifo_data;
    end
  end

  hbb_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init),
    .upd(we && is_data && state_q == ST_PAY), .din(ebit), .crc(crc)
  );

  hbb_bitmem #(.DEPTH(CAP), .IW(IW)) u_mem (
    .clk(clk), .we(we), .waddr(count_q[IW-1:0]), .wbit(ebit),
    .raddr(rd_addr), .rbit(rd_bit)
  );

  assign done      = (state_q == ST_DONE);
  assign too_long  = (state_q == ST_ERR);
  assign bit_count = count_q;

  hbb_query #(.AW(AW)) u_query (
    .clk(clk), .rst_n(rst_n), .query(query), .start(start),
    .ended(done || too_long), .count(count_q),
    .query_done(query_done), .query_count(query_count)
  );

  // Independent run-of-ones tracker over written stuffable bits
  logic [2:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (crc_init) begin
      run_q <= '0;
    end else if (we) begin
      if (state_q == ST_PAY || state_q == ST_FCS)
        run_q <= ebit ? ((run_q == 3'd5) ? 3'd5 : run_q + 3'd1) : 3'd0;
      else if (state_q == ST_CLOSE)
        run_q <= '0;
    end
  end

  // R3: never six ones in a row inside the stuffed fields
  assert_stuff_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && run_q == 3'd5) |-> !ebit);
  // R6: done and too_long are exclusive
  assert_end_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && too_long));
  // R6: a finished frame holds until the next start
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(bit_count)));
  // R7: overflow is sticky and pins the count at capacity
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (too_long && !start) |=> too_long);
  assert_err_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    too_long |-> (bit_count == AW'(CAP)));
  // R10: bytes are only taken while a payload byte is wanted and offered
  assert_pop_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_valid && state_q == ST_PAY));
endmodule

// File: tb/hbb_frame_builder_bench.sv
`timescale 1ns/1ps
module hbb_frame_builder_bench;
  localparam int SB = 64, NS = 3, LW = 5;
  localparam int CAP = SB * NS;
  localparam int IW = $clog2(CAP), AW = $clog2(CAP + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, query, fifo_valid, fifo_pop, rd_bit, query_done, done, too_long;
  logic [LW-1:0] msg_len;
  logic [7:0] fifo_data;
  logic [IW-1:0] rd_addr;
  logic [AW-1:0] query_count, bit_count;

  hbb_frame_builder #(.SLOT_BITS(SB), .SLOTS(NS), .LEN_W(LW)) u_hbb_frame_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .rd_addr(rd_addr), .rd_bit(rd_bit), .query(query), .query_done(query_done),
    .query_count(query_count), .bit_count(bit_count), .done(done), .too_long(too_long)
  );

  int total = 0, bad = 0;
  logic [7:0] fq [0:255];
  logic [7:0] pay [0:31];
  int rp, wp;
  bit stall_en, tog;
  int exp_bits [0:511];
  int exp_len;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= 0;
      tog <= 1'b0;
    end else begin
      tog <= ~tog;
      if (fifo_pop) rp <= rp + 1;
    end
  end
  assign fifo_valid = (rp != wp) && (!stall_en || tog);
  assign fifo_data  = fq[rp % 256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void put(inout int k, input int v);
    if (k < 512) exp_bits[k] = v;
    k++;
  endfunction

  function automatic int ref_build(input int n);
    int k = 0, ones = 0, d;
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 24; i++) put(k, i % 2);
    for (int i = 0; i < 8; i++) put(k, (8'h7E >> i) & 1);
    for (int b = 0; b < n; b++)
      for (int j = 0; j < 8; j++) begin
        d = (pay[b] >> j) & 1;
        put(k, d);
        c = (c >> 1) ^ (((c[0] ^ d[0]) != 0) ? 16'h8408 : 16'h0);
        ones = d ? ones + 1 : 0;
        if (ones == 5) begin put(k, 0); ones = 0; end
      end
    c = ~c;
    for (int j = 0; j < 16; j++) begin
      d = c[j];
      put(k, d);
      ones = d ? ones + 1 : 0;
      if (ones == 5) begin put(k, 0); ones = 0; end
    end
    for (int i = 0; i < 8; i++) put(k, (8'h7E >> i) & 1);
    return k;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    wp = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_case(input int n, input int mode, input bit stl, input bit poke, input bit late_q);
    int base, cyc, mism, lim, cnt0;
    bit early;
    string tag;
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: pay[i] = 8'h00;
        1: pay[i] = 8'hFF;
        2: pay[i] = 8'((i * 37 + n * 11 + 5) & 255);
        default: pay[i] = 8'h7E ^ 8'(i);
      endcase
      fq[wp % 256] = pay[i];
      wp++;
    end
    exp_len = ref_build(n);
    stall_en = stl;
    base = rp;
    start = 1'b1; msg_len = LW'(n);
    @(negedge clk);
    start = 1'b0; query = !late_q;
    @(negedge clk);
    query = 1'b0;
    early = 1'b0; cyc = 0;
    while (!(done || too_long) && cyc < 4000) begin
      if (query_done) early = 1'b1;
      if (poke && cyc == 20) begin start = 1'b1; msg_len = LW'(3); end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(!early, "R8 early answer", int'(early), 0);
    if (late_q) begin
      // R8: query after the end is answered on the next cycle
      query = 1'b1;
      @(negedge clk);
      query = 1'b0;
    end else begin
      @(negedge clk);
    end
    lim = (exp_len > CAP) ? CAP : exp_len;
    chk(query_done == 1'b1, "R8 answer pulse", int'(query_done), 1);
    chk(int'(query_count) == lim, "R8 answer count", int'(query_count), lim);
    if (exp_len <= CAP) begin
      chk(done && !too_long, "R6 done", int'(done), 1);
      chk(int'(bit_count) == exp_len, "R5 bit count", int'(bit_count), exp_len);
      chk(rp - base == n, "R10 bytes popped", rp - base, n);
    end else begin
      chk(too_long && !done, "R7 too_long", int'(too_long), 1);
      chk(int'(bit_count) == CAP, "R7 count at cap", int'(bit_count), CAP);
    end
    mism = 0;
    for (int a = 0; a < lim; a++) begin
      rd_addr = IW'(a);
      #0.1;
      if (int'(rd_bit) != exp_bits[a]) mism++;
    end
    tag = (mode == 1) ? "R3 frame bits" : ((mode == 0) ? "R2 frame bits" : "R4 frame bits");
    if (poke) tag = "R9 frame after ignored start";
    if (stl) tag = {tag, " R10 stalled"};
    chk(mism == 0, tag, mism, 0);
    @(negedge clk);
    chk(query_done == 1'b0, "R8 single pulse", int'(query_done), 0);
    if (late_q && exp_len <= CAP) begin
      cnt0 = int'(bit_count);
      repeat (10) @(negedge clk);
      chk(done && int'(bit_count) == cnt0, "R6 hold", int'(bit_count), cnt0);
    end
    if (too_long) do_reset();
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; query = 1'b0; msg_len = '0; rd_addr = '0;
    stall_en = 1'b0; wp = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done && !too_long && !query_done && !fifo_pop && bit_count == '0,
        "R1 reset outputs", int'(bit_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !too_long && bit_count == '0, "R1 idle after release", int'(done), 0);
    for (int n = 0; n <= 20; n++)
      for (int m = 0; m < 4; m++)
        run_case(n, m, ((n + m) % 2) == 1, (n == 9 && m == 2), (n == 5 && m == 3));
    run_case(31, 1, 1'b0, 1'b0, 1'b0);
    run_case(17, 0, 1'b1, 1'b0, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule